// File: doc/BRIEF.md
# Searching Circular Shift Unit

This unit rotates an operand bit by bit, either a single 32-bit word or a 64-bit pair of words, and stops as soon as a 1 sits in the most significant position. It can also stop when a signed step budget runs out. The caller supplies the operands, a single/double select and a 7-bit two's-complement count, then pulses `start`. The unit returns the rotated word(s) and a residual-count word. It also returns two flags: one says whether the top bit changed during the operation, the other says whether the operation ended with a 1 in the top bit.

The control is a three-state machine. S_IDLE waits for `start`, and a sampled start (transition "launch") loads the operands and moves to S_RUN. In S_RUN the unit rotates one position per clock and stays in S_RUN (transition "step") while the count is non-zero and the top bit is 0. When either ending condition holds, the machine moves to S_DONE (transition "finish"). S_DONE raises `done` for one cycle and then always returns to S_IDLE (transition "retire"). Results stay on the outputs until the next launch.

Top module: `srch_rot_unit`

## Requirements
- R1: `count` is 7-bit two's complement with bit 6 as the sign. A positive value rotates left (toward bit 31 of `op_hi`) by up to C positions. A negative value rotates right by up to |C| positions. -64 allows 64 steps.
- R2: With `dbl_mode`=0 only `op_hi` rotates, as a 32-bit ring, and `res_lo` equals `op_lo` unchanged.
- R3: With `dbl_mode`=1, {`op_hi`,`op_lo`} forms one 64-bit ring with `op_hi` as the upper half. Bits carry across both halves and wrap from end to end.
- R4: Rotation stops after |C| steps, or earlier as soon as bit 31 of the high word is 1, whichever comes first.
- R5: If bit 31 of `op_hi` is 1 at launch, no rotation occurs and the residual equals the original count.
- R6: `resid` bits 31:7 are 0. Bits 6:0 hold C minus the steps taken for a left shift, or C plus the steps taken for a right shift, so a shift that uses its whole count leaves 0.
- R7: `flag_chg` is 1 exactly when bit 31 of the high word at the end differs from its value at launch.
- R8: `flag_one` is 1 exactly when the operation ends with a 1 in bit 31 of the high word.
- R9: One position is rotated per clock. After the edge that samples `start`, `done` goes high following steps+2 rising edges, counting that edge.
- R10: `done` is a one-cycle pulse. `busy` is 0 after reset and 1 from launch until `done` has fallen. Outputs hold their values until the next launch.
- R11: `start` is ignored while `busy` is 1, and the running operation's results are unaffected.
- R12: A count of zero completes without rotation. The residual is 0 and the flags are evaluated on the unchanged operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, sampled in S_IDLE only |
| dbl_mode | input | 1 | 1 selects the 64-bit pair ring |
| count | input | 7 | Signed step budget and direction |
| op_hi | input | 32 | High operand word |
| op_lo | input | 32 | Low operand word |
| res_hi | output | 32 | Rotated high word |
| res_lo | output | 32 | Rotated low word (unchanged in single mode) |
| resid | output | 32 | Residual count, zero-extended from 7 bits |
| flag_chg | output | 1 | Top bit changed during the operation |
| flag_one | output | 1 | Operation ended with top bit 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The directed cases target the two ways an operation can end, including a case where both hold on the same step. A design that checks the top bit after rotating rather than before would overshoot by one position and return a residual off by one. Double-mode cases move a 1 across the word boundary and wrap it from bit 0 to bit 63. A ring that is only 32 bits wide would fail to find the bit or would corrupt the low word. Count extremes (+63, -64, 0) and an operand that already has its top bit set expose sign handling in the residual, and a design that rotates before checking would clear the top bit. A second start pulsed mid-run shows whether the unit wrongly reloads its operands.

// File: rtl/srch_rot_pkg.sv
package srch_rot_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 7;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } rot_state_t;
endpackage

// File: rtl/srch_rot_fsm.sv
module srch_rot_fsm
    import srch_rot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic at_end,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    rot_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start)  state_d = S_RUN;   // launch
            S_RUN:   if (at_end) state_d = S_DONE;  // finish (else step)
            S_DONE:              state_d = S_IDLE;  // retire
            default:             state_d = S_IDLE;
        endcase
    end

    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            S_RUN:   step = !at_end;
            S_DONE:  done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |=> (state_q == S_RUN || state_q == S_DONE));
endmodule

// File: rtl/srch_rot_path.sv
module srch_rot_path
    import srch_rot_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          dbl_in,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  op_hi,
    input  logic [W-1:0]  op_lo,
    output logic [W-1:0]  ring_hi,
    output logic [W-1:0]  ring_lo,
    output logic [CW-1:0] rem,
    output logic          msb_now,
    output logic          msb_init,
    output logic          at_end
);
    localparam int RW = 2 * W;

    logic [W-1:0]  hi_q, lo_q;
    logic [CW-1:0] rem_q;
    logic          left_q, dbl_q, msb0_q;
    logic [RW-1:0] pair, pair_rot;
    logic [W-1:0]  hi_rot;

    assign pair = {hi_q, lo_q};

    always_comb begin
        if (left_q) begin
            pair_rot = {pair[RW-2:0], pair[RW-1]};
            hi_rot   = {hi_q[W-2:0], hi_q[W-1]};
        end else begin
            pair_rot = {pair[0], pair[RW-1:1]};
            hi_rot   = {hi_q[0], hi_q[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            rem_q  <= '0;
            left_q <= 1'b0;
            dbl_q  <= 1'b0;
            msb0_q <= 1'b0;
        end else if (load) begin
            hi_q   <= op_hi;
            lo_q   <= op_lo;
            rem_q  <= count;
            left_q <= !count[CW-1];
            dbl_q  <= dbl_in;
            msb0_q <= op_hi[W-1];
        end else if (step) begin
            if (dbl_q) begin
                hi_q <= pair_rot[RW-1:W];
                lo_q <= pair_rot[W-1:0];
            end else begin
                hi_q <= hi_rot;
            end
            rem_q <= left_q ? rem_q - CW'(1) : rem_q + CW'(1);
        end
    end

    assign ring_hi  = hi_q;
    assign ring_lo  = lo_q;
    assign rem      = rem_q;
    assign msb_now  = hi_q[W-1];
    assign msb_init = msb0_q;
    assign at_end   = (rem_q == '0) || hi_q[W-1];

    // R6
    rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q == $past(rem_q) + CW'(1) || rem_q == $past(rem_q) - CW'(1)));

    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !dbl_q) |=> $stable(lo_q));
endmodule

// File: rtl/srch_rot_unit.sv
module srch_rot_unit
    import srch_rot_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dbl_mode,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  op_hi,
    input  logic [W-1:0]  op_lo,
    output logic [W-1:0]  res_hi,
    output logic [W-1:0]  res_lo,
    output logic [W-1:0]  resid,
    output logic          flag_chg,
    output logic          flag_one,
    output logic          busy,
    output logic          done
);
    logic          load, step, at_end, msb_now, msb_init;
    logic [CW-1:0] rem;

    srch_rot_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .at_end (at_end),
        .load   (load),
        .step   (step),
        .busy   (busy),
        .done   (done)
    );

    srch_rot_path #(.W(W), .CW(CW)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .dbl_in   (dbl_mode),
        .count    (count),
        .op_hi    (op_hi),
        .op_lo    (op_lo),
        .ring_hi  (res_hi),
        .ring_lo  (res_lo),
        .rem      (rem),
        .msb_now  (msb_now),
        .msb_init (msb_init),
        .at_end   (at_end)
    );

    assign resid    = {{(W-CW){1'b0}}, rem};
    assign flag_chg = msb_now ^ msb_init;
    assign flag_one = msb_now;

    // R4
    stop_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && msb_now) |=> done);

    // R4
    end_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem == '0 || msb_now));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_hi) && $stable(res_lo) && $stable(resid)));
endmodule

// File: tb/srch_rot_unit_tb_top.sv
module srch_rot_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [6:0]  count = '0;
    logic [31:0] op_hi = '0, op_lo = '0;
    logic [31:0] res_hi, res_lo, resid;
    logic        flag_chg, flag_one, busy, done;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    srch_rot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dbl_mode(dbl_mode),
        .count(count), .op_hi(op_hi), .op_lo(op_lo),
        .res_hi(res_hi), .res_lo(res_lo), .resid(resid),
        .flag_chg(flag_chg), .flag_one(flag_one), .busy(busy), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Spec model: rotate until budget spent or top bit is 1.
    task automatic model(input logic [31:0] hi, input logic [31:0] lo,
                         input logic dbl, input logic [6:0] c,
                         output logic [31:0] eh, output logic [31:0] el,
                         output logic [6:0] er, output int steps);
        logic [63:0] pr;
        pr = {hi, lo};
        er = c;
        steps = 0;
        while (er != 7'd0 && !pr[63]) begin
            if (!c[6]) begin
                if (dbl) pr = {pr[62:0], pr[63]};
                else     pr[63:32] = {pr[62:32], pr[63]};
                er = er - 7'd1;
            end else begin
                if (dbl) pr = {pr[0], pr[63:1]};
                else     pr[63:32] = {pr[32], pr[63:33]};
                er = er + 7'd1;
            end
            steps++;
        end
        eh = pr[63:32];
        el = pr[31:0];
    endtask

    task automatic run_op(input string tag, input logic [31:0] hi, input logic [31:0] lo,
                          input logic dbl, input logic [6:0] c, input logic poke);
        logic [31:0] eh, el;
        logic [6:0]  er;
        int          steps, n;
        model(hi, lo, dbl, c, eh, el, er, steps);
        @(negedge clk);
        op_hi = hi; op_lo = lo; dbl_mode = dbl; count = c; start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R11: second start mid-run with other operands
            op_hi = 32'h8000_0000; op_lo = 32'h1111_1111; count = 7'd1; start = 1'b1;
        end
        while (!done && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
        end
        check(tag, "R9 latency", 64'(n), 64'(steps + 2));
        check(tag, "R1 R3 R4 res_hi", 64'(res_hi), 64'(eh));
        check(tag, "R2 R3 res_lo", 64'(res_lo), 64'(el));
        check(tag, "R6 resid", 64'(resid), {57'd0, er});
        check(tag, "R7 flag_chg", 64'(flag_chg), 64'(eh[31] ^ hi[31]));
        check(tag, "R8 flag_one", 64'(flag_one), 64'(eh[31]));
        @(negedge clk);
        check(tag, "R10 done pulse", {62'd0, done, busy}, 64'd0);
        check(tag, "R10 hold", {res_hi, resid}, {eh, 25'd0, er});
    endtask

    task automatic t_reset;
        check("R10", "reset busy/done", {62'd0, busy, done}, 64'd0);
        check("R6", "reset resid", 64'(resid), 64'd0);
    endtask

    task automatic t_single_left;  run_op("R1 R2", 32'h0000_0100, 32'hDEAD_BEEF, 1'b0, 7'd30, 1'b0); endtask
    task automatic t_single_right; run_op("R1",    32'h0000_0004, 32'h0, 1'b0, 7'h7B, 1'b0); endtask
    task automatic t_exhaust;      run_op("R4",    32'h0000_0001, 32'h0, 1'b0, 7'd4, 1'b0); endtask
    task automatic t_both_end;     run_op("R4",    32'h1000_0000, 32'h0, 1'b0, 7'd3, 1'b0); endtask
    task automatic t_msb_set;      run_op("R5",    32'h8000_0001, 32'h5, 1'b0, 7'h77, 1'b0); endtask
    task automatic t_zero;         run_op("R12",   32'h1234_5678, 32'h9, 1'b1, 7'd0, 1'b0); endtask
    task automatic t_dbl_left;     run_op("R3",    32'h0, 32'h0000_8000, 1'b1, 7'd63, 1'b0); endtask
    task automatic t_dbl_right;    run_op("R3 R1", 32'h0, 32'h0000_0001, 1'b1, 7'h40, 1'b0); endtask
    task automatic t_dbl_exhaust;  run_op("R3 R6", 32'h0000_0F00, 32'hC000_0000, 1'b1, 7'h7D, 1'b0); endtask
    task automatic t_ignore;       run_op("R11",   32'h0000_0010, 32'h2, 1'b0, 7'd40, 1'b1); endtask

    initial begin
        #2000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single_left();
        t_single_right();
        t_exhaust();
        t_both_end();
        t_msb_set();
        t_zero();
        t_dbl_left();
        t_dbl_right();
        t_dbl_exhaust();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule